// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block works out the bit period of a serial receive line from one calibration character, 0x55. It produces a divisor that a baud rate generator can load directly. The 0x55 byte is sent least significant bit first, so the line toggles on every bit. That gives five rising edges across the frame: the first at the end of the start bit and the last as bit 7 hands over to the stop bit. These two edges are eight bit periods apart.

Software raises `start` for one cycle. If the line is low at that moment, the detector first waits for the line to go high, then waits for a falling start edge, then waits for the first rising edge. At that first rising edge a counter is loaded with one. The counter advances on a prescaled tick that runs at one eighth of the chosen generator base clock. Because the span is eight bit periods, the final count is the average bit time in generator units. The count stops at the fifth rising edge. The detector then stores it, drops `busy` and presents the result as a valid word.

The result interface follows valid/ready rules. `res_valid` stays high, and the stored count does not change, until the consumer raises `res_ready`. A `res_ready` pulse while `res_valid` is low does nothing. There is no back-pressure on the measurement itself: a new measurement can be started while an old result is still waiting.

Top module: `abd_detector`

## Requirements
- R1: After reset, `busy`, `res_valid` and `ovf` are 0 and `count_raw` is 0.
- R2: A `start` pulse while idle makes `busy` 1 on the next cycle. A `start` pulse while `busy` is 1 is ignored, and the measurement in progress finishes with its normal result.
- R3: If `start` arrives while the line is low, the detector waits for the line to return high before it looks for a start edge. A character sent after that is still measured correctly.
- R4: `count_raw` equals 1 plus the number of prescaled ticks between the first and fifth rising edge, within ±1. The tick period in system clocks is selected by {`sel_wide`,`sel_fast`}: 00 gives 512, 01 gives 128, 10 gives 128 and 11 gives 32.
- R5: In the cycle where `busy` falls, `res_valid` is 1.
- R6: `res_valid` stays 1 until a cycle with `res_ready` high. It is 0 in the cycle after that.
- R7: `count_raw` does not change while the detector is idle. It changes only in the cycle in which a measurement ends.
- R8: `divisor` always equals `count_raw` minus one, taken modulo 2^CNT_W.
- R9: If the counter would go past its all-ones value, it saturates and `ovf` is set. The sequence then ends: `busy` goes to 0, `res_valid` goes to 1 and `count_raw` is all ones.
- R10: `narrow_ovf` is 1 when `sel_wide` is 0 and `count_raw` has any bit set at position 8 or above. It is 0 when `sel_wide` is 1.
- R11: `ovf` stays set until the next accepted `start`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_async | input | 1 | Asynchronous serial receive line, idle high |
| sel_wide | input | 1 | Divisor width mode select (1 = 16-bit generator) |
| sel_fast | input | 1 | High-speed base clock select |
| start | input | 1 | One-cycle request to begin a measurement |
| busy | output | 1 | Measurement armed or running |
| res_valid | output | 1 | A stored result is waiting |
| res_ready | input | 1 | Consumer accepts the stored result |
| count_raw | output | CNT_W | Stored count, which starts at one |
| divisor | output | CNT_W | Stored count minus one |
| ovf | output | 1 | Sticky counter saturation flag |
| narrow_ovf | output | 1 | Result does not fit an 8-bit divisor in 8-bit mode |

## Verification
Some rules are checked by assertions on every cycle:
- the handover from `busy` to `res_valid`;
- that `res_valid` holds until it is accepted;
- that the stored count is frozen while idle;
- that a start from idle is accepted;
- that saturation forces an all-ones result.

Other behaviour can only be shown by the bench's scenarios:
- the accuracy of the measured count for each prescale setting;
- the wait for the line to go high before a start edge;
- that a second `start` is ignored while a measurement runs;
- the mode dependence of the narrow-overflow flag.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_HIGH,
    ST_WAIT_FALL,
    ST_WAIT_RISE,
    ST_MEASURE
  } abd_state_t;

  localparam int unsigned EDGES_AFTER_FIRST = 4;
endpackage

// File: rtl/abd_sync.sv
module abd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
  assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/abd_prescale.sv
module abd_prescale #(
  parameter int unsigned DIV_SLOW = 512,
  parameter int unsigned DIV_MID  = 128,
  parameter int unsigned DIV_FAST = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int unsigned PW = $clog2(DIV_SLOW);

  logic [PW-1:0] cnt;
  logic [PW-1:0] lim;

  always_comb begin
    case (sel)
      2'b00:   lim = PW'(DIV_SLOW - 1);
      2'b11:   lim = PW'(DIV_FAST - 1);
      default: lim = PW'(DIV_MID - 1);
    endcase
  end

  assign tick = run && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (clear || !run)  cnt <= '0;
    else if (cnt == lim)     cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/abd_counter.sv
module abd_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_one,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         sat
);
  assign sat = inc && (value == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     value <= '0;
    else if (load_one)              value <= W'(1);
    else if (inc && value != '1)    value <= value + 1'b1;
  end
endmodule

// File: rtl/abd_detector.sv
module abd_detector #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned SYNC_LEN = 2,
  parameter int unsigned DIV_SLOW = 512,
  parameter int unsigned DIV_MID  = 128,
  parameter int unsigned DIV_FAST = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_async,
  input  logic             sel_wide,
  input  logic             sel_fast,
  input  logic             start,
  output logic             busy,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [CNT_W-1:0] count_raw,
  output logic [CNT_W-1:0] divisor,
  output logic             ovf,
  output logic             narrow_ovf
);
  import abd_pkg::*;

  localparam int unsigned EW = $clog2(EDGES_AFTER_FIRST + 1);

  abd_state_t       state;
  logic [EW-1:0]    edges;
  logic             rx_lvl, rx_rise, rx_fall;
  logic             tick, sat, first_edge;
  logic [CNT_W-1:0] cnt_val;
  logic [CNT_W-1:0] raw_q;
  logic             valid_q, ovf_q;

  abd_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_async),
    .level(rx_lvl), .rise(rx_rise), .fall(rx_fall)
  );

  assign first_edge = (state == ST_WAIT_RISE) && rx_rise;

  abd_prescale #(.DIV_SLOW(DIV_SLOW), .DIV_MID(DIV_MID), .DIV_FAST(DIV_FAST)) u_pre (
    .clk(clk), .rst_n(rst_n), .clear(first_edge),
    .run(state == ST_MEASURE), .sel({sel_wide, sel_fast}), .tick(tick)
  );

  abd_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_one(first_edge),
    .inc((state == ST_MEASURE) && tick), .value(cnt_val), .sat(sat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      edges   <= '0;
      raw_q   <= '0;
      valid_q <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (valid_q && res_ready) valid_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          ovf_q <= 1'b0;
          state <= rx_lvl ? ST_WAIT_FALL : ST_WAIT_HIGH;
        end
        ST_WAIT_HIGH: if (rx_lvl)  state <= ST_WAIT_FALL;
        ST_WAIT_FALL: if (rx_fall) state <= ST_WAIT_RISE;
        ST_WAIT_RISE: if (rx_rise) begin
          edges <= '0;
          state <= ST_MEASURE;
        end
        ST_MEASURE: begin
          if (sat) begin
            ovf_q   <= 1'b1;
            raw_q   <= '1;
            valid_q <= 1'b1;
            state   <= ST_IDLE;
          end else if (rx_rise) begin
            if (edges == EW'(EDGES_AFTER_FIRST - 1)) begin
              raw_q   <= cnt_val;
              valid_q <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              edges <= edges + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state != ST_IDLE);
  assign res_valid  = valid_q;
  assign count_raw  = raw_q;
  assign divisor    = raw_q - 1'b1;
  assign ovf        = ovf_q;
  assign narrow_ovf = !sel_wide && (|raw_q[CNT_W-1:8]);
endmodule

// File: rtl/abd_detector_chk.sv
module abd_detector_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             res_valid,
  input logic             res_ready,
  input logic [CNT_W-1:0] count_raw,
  input logic             ovf
);
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R5
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_valid);

  // R6
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> res_valid);

  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy)) |-> $stable(count_raw));

  // R9
  saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> (count_raw == '1) && !busy && res_valid);
endmodule

bind abd_detector abd_detector_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .res_valid(res_valid), .res_ready(res_ready),
  .count_raw(count_raw), .ovf(ovf)
);

// File: tb/abd_detector_tb.sv
`timescale 1ns/1ps
module abd_detector_tb;
  localparam int CW = 10;

  logic clk = 1'b0, rst_n = 1'b0, rx = 1'b1;
  logic sel_wide = 1'b0, sel_fast = 1'b0, start = 1'b0, res_ready = 1'b0;
  logic busy, res_valid, ovf, narrow_ovf;
  logic [CW-1:0] count_raw, divisor;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  abd_detector #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_async(rx), .sel_wide(sel_wide),
    .sel_fast(sel_fast), .start(start), .busy(busy), .res_valid(res_valid),
    .res_ready(res_ready), .count_raw(count_raw), .divisor(divisor),
    .ovf(ovf), .narrow_ovf(narrow_ovf)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_near(string req, int act, int exp);
    checks++;
    if (act < exp - 1 || act > exp + 1) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d +/-1", req, act, exp);
    end
  endtask

  task automatic send_char(int p);
    rx = 1'b0;
    repeat (p) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = (i % 2 == 0);
      repeat (p) @(negedge clk);
    end
    rx = 1'b1;
    repeat (p) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk) res_ready = 1'b1;
    @(negedge clk) res_ready = 1'b0;
  endtask

  task automatic wait_valid();
    for (int i = 0; i < 60000; i++) begin
      if (res_valid) break;
      @(negedge clk);
    end
  endtask

  task automatic set_sel(int s);
    sel_wide = s[1];
    sel_fast = s[0];
  endtask

  // R1
  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 valid", res_valid, 0);
    chk("R1 ovf", ovf, 0);
    chk("R1 count", count_raw, 0);
  endtask

  // R4 R5 R8 R6 R2
  task automatic t_measure(int s, int p, int n);
    set_sel(s);
    pulse_start();
    chk("R2 busy after start", busy, 1);
    send_char(p);
    wait_valid();
    chk("R5 valid", res_valid, 1);
    chk("R5 busy cleared", busy, 0);
    chk_near("R4 count", int'(count_raw), 1 + 8 * p / n);
    chk("R8 divisor", divisor, CW'(count_raw - 1'b1));
    ack();
    chk("R6 valid cleared", res_valid, 0);
  endtask

  // R6 R7
  task automatic t_hold();
    logic [CW-1:0] saved;
    set_sel(3);
    pulse_start();
    send_char(64);
    wait_valid();
    saved = count_raw;
    repeat (30) @(negedge clk);
    chk("R6 valid held", res_valid, 1);
    chk("R7 count frozen", count_raw, saved);
    ack();
    chk("R6 valid after ready", res_valid, 0);
  endtask

  // R3
  task automatic t_low_start();
    set_sel(3);
    rx = 1'b0;
    repeat (10) @(negedge clk);
    pulse_start();
    repeat (40) @(negedge clk);
    chk("R3 armed while low", busy, 1);
    chk("R3 no result", res_valid, 0);
    rx = 1'b1;
    repeat (20) @(negedge clk);
    send_char(64);
    wait_valid();
    chk("R3 valid", res_valid, 1);
    chk_near("R3 count", int'(count_raw), 17);
    ack();
  endtask

  // R2 ignore while busy
  task automatic t_busy_start();
    set_sel(2);
    pulse_start();
    fork
      send_char(256);
      begin
        repeat (900) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
      end
    join
    wait_valid();
    chk("R2 valid", res_valid, 1);
    chk_near("R2 count unchanged by restart", int'(count_raw), 17);
    ack();
  endtask

  // R10
  task automatic t_narrow();
    set_sel(1);
    pulse_start();
    send_char(4100);
    wait_valid();
    chk_near("R10 count", int'(count_raw), 257);
    chk("R10 narrow flag in 8-bit mode", narrow_ovf, 1);
    sel_wide = 1'b1;
    @(negedge clk);
    chk("R10 narrow flag in 16-bit mode", narrow_ovf, 0);
    ack();
  endtask

  // R9 R11
  task automatic t_overflow();
    set_sel(3);
    pulse_start();
    fork
      send_char(4100);
    join_none
    wait_valid();
    chk("R9 ovf", ovf, 1);
    chk("R9 saturated", count_raw, (1 << CW) - 1);
    chk("R9 busy cleared", busy, 0);
    wait fork;
    repeat (10) @(negedge clk);
    chk("R11 ovf sticky", ovf, 1);
    ack();
    pulse_start();
    chk("R11 ovf cleared by start", ovf, 0);
    send_char(64);
    wait_valid();
    chk_near("R11 count after overflow", int'(count_raw), 17);
    ack();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_measure(3, 64, 32);
    t_measure(2, 256, 128);
    t_measure(1, 512, 128);
    t_measure(0, 1024, 512);
    t_hold();
    t_low_start();
    t_busy_start();
    t_narrow();
    t_overflow();
    finish_run();
  end
endmodule